// File: doc/BRIEF.md
# Clock Alignment Phase Sequencer

This block steps a clock synchronizer through its alignment schedule once a sync request is raised. The request is sampled on each rising clock edge. On the first edge that sees it high, the block leaves its idle state. For one cycle it sends the reference clock to the output path. For the next cycle it steers the feedback clock into the coarse delay line, sends the coarse-line output to the output path and pulses a capture strobe so that the coarse measurement is latched. From the third cycle it leaves both selectors where they are and hands control to a fine tuner through an enable. That tuner has a fixed budget of `FINE_CYCLES` cycles, three by default, so full alignment is reached at the end of cycle five.

Once the budget is used up, the block reports that it is aligned. It keeps the fine-tune enable high so that the tuner can keep tracking slow drift. Lowering the sync request at any point sends the block back to idle on the next edge and releases every control. Raising the request again restarts the schedule from its first cycle.

States, with the phase code each one reports:
- `ST_IDLE` (phase 0).
- `ST_REF`, the reference routing cycle (phase 1).
- `ST_MEAS`, the coarse measurement cycle (phase 1).
- `ST_FINE`, the fine tuning window (phase 2).
- `ST_LOCK`, aligned (phase 3).

Transitions:
- IDLE→REF when the request is high.
- REF→MEAS and MEAS→FINE while the request stays high.
- FINE→LOCK after `FINE_CYCLES` cycles in FINE.
- LOCK→LOCK while the request stays high.
- Any state→IDLE when the request is low.

Top module: `clk_align_seq`

## Requirements
- R1: While reset is active, and after it until a request is seen: phase is 0 (idle) and `fb_route`, `coarse_route`, `meas_capture` and `fine_en` are all 0.
- R2: On the first edge that samples `sync_req` high in idle, the block enters cycle 1. In cycle 1, phase is 1 (coarse), `coarse_route` is 0 (the output path carries the reference clock), `fb_route` is 0, `meas_capture` is 0 and `fine_en` is 0.
- R3: In cycle 2, phase is 1, `fb_route` is 1 (the feedback clock feeds the coarse line), `coarse_route` is 1 (the output path carries the coarse-line output), `meas_capture` is 1 and `fine_en` is 0.
- R4: `meas_capture` is a single-cycle pulse, and it occurs exactly once per request, in cycle 2.
- R5: In cycles 3 to 2+`FINE_CYCLES` (cycles 3 to 5 by default), phase is 2 (fine), `fine_en` is 1, and `fb_route` and `coarse_route` hold their cycle 2 values of 1.
- R6: From cycle 3+`FINE_CYCLES` on, while the request stays high, phase is 3 (aligned), `fine_en` stays 1 and both selectors stay at 1.
- R7: An edge that samples `sync_req` low puts the block in idle, with phase 0 and every control output 0. This holds in any state.
- R8: A request raised again after a drop restarts the schedule at cycle 1, including when the drop happened from the aligned state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_req | input | 1 | Alignment request; high starts and holds the schedule, low aborts it |
| fb_route | output | 1 | Input selector: 1 routes the feedback clock into the coarse line |
| coarse_route | output | 1 | Output selector: 0 selects the reference clock, 1 selects the coarse-line output |
| meas_capture | output | 1 | One-cycle strobe that latches the coarse measurement |
| fine_en | output | 1 | Enable for the fine tuner |
| phase | output | 2 | Phase code: 0 idle, 1 coarse, 2 fine, 3 aligned |

## Verification
All outputs are decoded from registered state. Each result is therefore due in the same cycle as the edge that samples the request. Cycle n of the schedule begins at the n-th consecutive edge that sees `sync_req` high, and an abort shows on the first edge that sees it low.

The bench changes `sync_req` on the falling edge. It advances its own count of consecutive high samples on the rising edge, and it compares every output shortly after that edge against values derived from that count. The capture pulse is additionally counted over each full request, so that one extra pulse or one missing pulse is caught.

// File: rtl/align_seq_pkg.sv
package align_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REF  = 3'd1,
        ST_MEAS = 3'd2,
        ST_FINE = 3'd3,
        ST_LOCK = 3'd4
    } seq_state_e;

    localparam logic [1:0] PH_IDLE    = 2'd0;
    localparam logic [1:0] PH_COARSE  = 2'd1;
    localparam logic [1:0] PH_FINE    = 2'd2;
    localparam logic [1:0] PH_ALIGNED = 2'd3;

endpackage

// File: rtl/align_seq_fsm.sv
module align_seq_fsm
    import align_seq_pkg::*;
#(
    parameter int FINE_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_req,
    output seq_state_e state
);

    localparam int CNT_W = $clog2(FINE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FINE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] fine_cnt_q, fine_cnt_d;

    always_comb begin
        state_d    = state_q;
        fine_cnt_d = fine_cnt_q;
        if (!sync_req) begin
            state_d    = ST_IDLE;
            fine_cnt_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_REF;
                ST_REF:  state_d = ST_MEAS;
                ST_MEAS: begin
                    state_d    = ST_FINE;
                    fine_cnt_d = '0;
                end
                ST_FINE: begin
                    if (fine_cnt_q == CNT_LAST) begin
                        state_d = ST_LOCK;
                    end else begin
                        fine_cnt_d = fine_cnt_q + 1'b1;
                    end
                end
                ST_LOCK: state_d = ST_LOCK;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fine_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            fine_cnt_q <= fine_cnt_d;
        end
    end

    assign state = state_q;

    // R5: the fine window never lasts longer than its budget of cycles
    a_r5_fine_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINE) |-> (fine_cnt_q <= CNT_LAST));

    // R7: a low request always leads to idle on the next edge
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req |=> (state_q == ST_IDLE));

endmodule

// File: rtl/align_seq_dec.sv
module align_seq_dec
    import align_seq_pkg::*;
(
    input  seq_state_e state,
    output logic       fb_route,
    output logic       coarse_route,
    output logic       meas_capture,
    output logic       fine_en,
    output logic [1:0] phase
);

    always_comb begin
        fb_route     = 1'b0;
        coarse_route = 1'b0;
        meas_capture = 1'b0;
        fine_en      = 1'b0;
        phase        = PH_IDLE;
        unique case (state)
            ST_IDLE: begin
                phase = PH_IDLE;
            end
            ST_REF: begin
                phase = PH_COARSE;
            end
            ST_MEAS: begin
                fb_route     = 1'b1;
                coarse_route = 1'b1;
                meas_capture = 1'b1;
                phase        = PH_COARSE;
            end
            ST_FINE: begin
                fb_route     = 1'b1;
                coarse_route = 1'b1;
                fine_en      = 1'b1;
                phase        = PH_FINE;
            end
            ST_LOCK: begin
                fb_route     = 1'b1;
                coarse_route = 1'b1;
                fine_en      = 1'b1;
                phase        = PH_ALIGNED;
            end
            default: begin
                phase = PH_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/clk_align_seq.sv
module clk_align_seq
    import align_seq_pkg::*;
#(
    parameter int FINE_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_req,
    output logic       fb_route,
    output logic       coarse_route,
    output logic       meas_capture,
    output logic       fine_en,
    output logic [1:0] phase
);

    seq_state_e state;

    align_seq_fsm #(
        .FINE_CYCLES(FINE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .state    (state)
    );

    align_seq_dec u_dec (
        .state        (state),
        .fb_route     (fb_route),
        .coarse_route (coarse_route),
        .meas_capture (meas_capture),
        .fine_en      (fine_en),
        .phase        (phase)
    );

    // R2: a request seen in idle opens cycle 1 with the reference clock routed out
    a_r2_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && sync_req) |=>
            (phase == PH_COARSE && !coarse_route && !meas_capture && !fine_en));

    // R4: the capture strobe never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        meas_capture |=> !meas_capture);

    // R3: the capture is followed either by the fine window or by an abort
    a_r3_capture_then_fine: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_capture && sync_req) |=> (fine_en && phase == PH_FINE));

    // R5: the selectors hold still while the fine tuner is in control
    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_en && sync_req) |=> ($stable(fb_route) && $stable(coarse_route)));

    // R6: the aligned state persists while the request stays high
    a_r6_lock_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ALIGNED && sync_req) |=> (phase == PH_ALIGNED && fine_en));

    // R7: an abort releases the fine tuner on the next edge
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req |=> (!fine_en && !meas_capture && !fb_route && !coarse_route));

endmodule

// File: tb/test_clk_align_seq.sv
module test_clk_align_seq;

    localparam int CLK_PERIOD = 10;
    localparam int FINE_N     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_req = 1'b0;
    logic       fb_route, coarse_route, meas_capture, fine_en;
    logic [1:0] phase;

    int n_vec = 0;
    int n_bad = 0;
    int run_len = 0;      // consecutive edges that sampled sync_req high
    int cap_count = 0;    // capture pulses seen in the current request
    bit finished = 1'b0;

    clk_align_seq #(.FINE_CYCLES(FINE_N)) i_clk_align_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_req     (sync_req),
        .fb_route     (fb_route),
        .coarse_route (coarse_route),
        .meas_capture (meas_capture),
        .fine_en      (fine_en),
        .phase        (phase)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected output word {phase, fb, coarse, capture, fine} for cycle index k.
    function automatic logic [5:0] expect_word(input int k);
        if (k == 0)               return {2'd0, 4'b0000};
        else if (k == 1)          return {2'd1, 4'b0000};
        else if (k == 2)          return {2'd1, 4'b1110};
        else if (k <= 2 + FINE_N) return {2'd2, 4'b1101};
        else                      return {2'd3, 4'b1101};
    endfunction

    function automatic string req_tag(input int k);
        if (k == 0)               return "R7";
        else if (k == 1)          return "R2";
        else if (k == 2)          return "R3";
        else if (k <= 2 + FINE_N) return "R5";
        else                      return "R6";
    endfunction

    task automatic compare(input string tag, input int k);
        logic [5:0] got;
        logic [5:0] exp;
        got = {phase, fb_route, coarse_route, meas_capture, fine_en};
        exp = expect_word(k);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, k, got, exp);
        end
    endtask

    task automatic step(input logic s);
        @(negedge clk);
        sync_req = s;
        @(posedge clk);
        if (s) begin
            if (run_len < 1000) run_len++;
        end else begin
            run_len = 0;
        end
        #1;
        if (meas_capture) cap_count++;
        compare(req_tag(run_len), run_len);
    endtask

    // Closes one request and checks that it produced one capture (R4).
    task automatic check_capture_once(input int expected);
        n_vec++;
        if (cap_count != expected) begin
            n_bad++;
            $display("FAIL R4 capture pulses actual=%0d expected=%0d", cap_count, expected);
        end
        cap_count = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: outputs idle during reset, even with a request pending
        sync_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 0);
        @(negedge clk);
        sync_req = 1'b0;
        rst_n = 1'b1;
        step(1'b0);
        compare("R1", 0);

        // Full schedule held high: R2, R3, R5, R6
        for (int i = 0; i < 12; i++) step(1'b1);
        step(1'b0);
        check_capture_once(1);

        // R7: abort in cycle 2, then R8 restart from cycle 1
        step(1'b1);
        step(1'b1);
        step(1'b0);
        check_capture_once(1);
        for (int i = 0; i < 7; i++) step(1'b1);

        // R7 and R8: abort from the aligned state, then restart
        step(1'b0);
        check_capture_once(1);
        for (int i = 0; i < 4; i++) step(1'b1);

        // R7: abort inside the fine window
        step(1'b0);
        check_capture_once(1);
        step(1'b0);

        // R7: a request lasting a single cycle gives no capture
        step(1'b1);
        step(1'b0);
        check_capture_once(0);

        // Random request patterns, mostly long high runs
        for (int i = 0; i < 3000; i++) begin
            logic s;
            s = ($urandom % 6) != 0;
            step(s);
            if (!s) check_capture_once((cap_count > 0) ? 1 : 0);
        end
        step(1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule